// File: doc/BRIEF.md
# Table-Based Sine/Cosine Generator

This block turns an angle given in degrees into its sine and its cosine. It looks both values up in a constant table that spans one full turn in 720 equal half-degree steps. The table is computed when the design is elaborated. Every address in the table is used directly, so no quadrant folding or sign correction happens on the way out. Results are quantised to the nearest table sample, and no interpolation is done between entries.

Angles arrive on a valid/ready input stream and results leave on a valid/ready output stream. A single register stage sits between the two. An accepted angle appears at the output on the next clock. While the output is stalled the block holds its result and refuses new angles. It takes new angles again as soon as the downstream side takes the held result, and it can do so in that same cycle.

Top module: `sincos_table_gen`

## Requirements
- R1: `in_angle` is an 18-bit two's complement number with 5 fraction bits, in degrees. One LSB is 1/32 degree and the range is -4096 to just under +4096 degrees.
- R2: The table index is the angle multiplied by 2 and rounded to the nearest half-degree step, with ties going upward. In LSB units the index is floor((in_angle + 8) / 16).
- R3: The index wraps modulo 720 for every representable angle. Negative angles and angles of 360 degrees or more therefore select the same entry as their equivalent in the range 0 to 360 degrees.
- R4: Entry k holds v = sin(k·0.5°) for `out_sin` and v = cos(k·0.5°) for `out_cos`. Each is coded in 12 bits as a sign bit, one integer bit and 10 fraction bits. The code is built from m = round(|v|·1024). It is m when v ≥ 0 or m = 0, and the bitwise inverse of m when v < 0. So +1.0 is 12'h400, -1.0 is 12'hBFF, and cos(240°) is 12'hDFF.
- R5: An angle accepted on a clock edge (`in_valid` and `in_ready` both high) produces `out_valid` high with its results after that same edge. The latency is one clock.
- R6: Back-pressure. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While that holds, `out_sin`, `out_cos` and `out_valid` stay unchanged, and `in_angle` has no effect.
- R7: While `rst` is high on a clock edge, the next state has `out_valid`, `out_sin` and `out_cos` all zero.
- R8: When the held result is taken (`out_ready` high) and no new angle is offered, `out_valid` falls after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An angle is offered |
| in_ready | output | 1 | The block can take an angle this cycle |
| in_angle | input | 18 | Angle in degrees, two's complement, 5 fraction bits |
| out_valid | output | 1 | A result is held on the outputs |
| out_ready | input | 1 | The downstream side takes the held result |
| out_sin | output | 12 | Sine, sign plus 1 integer bit plus 10 fraction bits |
| out_cos | output | 12 | Cosine, same coding as `out_sin` |

## Verification
A sweep over every half-degree from 0 to 359.5 degrees visits each table entry once. Any fault in table contents or in the negative-value coding shows up there. Angles just below, on and just above the half-step boundaries, on both sides of zero, separate correct rounding from truncation or rounding toward zero. Angles far outside one turn, including both range extremes and negative angles, expose wrap errors that the sweep cannot reach. Random angles combined with random gaps on `in_valid` and random stalls on `out_ready` test the hold, drain and single-cycle latency rules against a behavioural model compared on every clock.

// File: rtl/sincos_pkg.sv
package sincos_pkg;
  localparam int unsigned ANGLE_INT_BITS  = 12;
  localparam int unsigned ANGLE_FRAC_BITS = 5;
  localparam int unsigned TABLE_STEPS     = 720;
  localparam int unsigned VALUE_FRAC_BITS = 10;
  localparam int unsigned VALUE_BITS      = 12;
  localparam real         PI_R            = 3.14159265358979323846;
endpackage

// File: rtl/sincos_angle_index.sv
module sincos_angle_index #(
  parameter int unsigned INT_BITS  = sincos_pkg::ANGLE_INT_BITS,
  parameter int unsigned FRAC_BITS = sincos_pkg::ANGLE_FRAC_BITS,
  parameter int unsigned STEPS     = sincos_pkg::TABLE_STEPS,
  localparam int unsigned ANG_W    = 1 + INT_BITS + FRAC_BITS,
  localparam int unsigned IDX_W    = $clog2(STEPS)
) (
  input  logic [ANG_W-1:0] angle,
  output logic [IDX_W-1:0] idx
);
  // two table steps per degree: one step spans 2^(FRAC_BITS-1) LSBs
  localparam int unsigned STEP_SH = FRAC_BITS - 1;
  localparam int unsigned HALF    = 1 << (STEP_SH - 1);
  localparam int unsigned HMAG    = 1 << (INT_BITS + 1);
  localparam int unsigned OFFS    = STEPS * ((HMAG + STEPS - 1) / STEPS);
  localparam int unsigned NSTG    = $clog2((HMAG + OFFS) / STEPS + 1);
  localparam int unsigned WW      = ANG_W + 2;

  logic signed [ANG_W:0]  rounded;
  logic signed [WW-1:0]   steps_s;
  logic        [WW-1:0]   red [NSTG+1];

  assign rounded = $signed({angle[ANG_W-1], angle}) + $signed((ANG_W+1)'(HALF));
  assign steps_s = $signed({{(WW-ANG_W-1){rounded[ANG_W]}}, rounded}) >>> STEP_SH;
  assign red[0]  = $unsigned(steps_s) + WW'(OFFS);

  for (genvar k = 0; k < NSTG; k++) begin : g_wrap
    localparam logic [WW-1:0] LIM = WW'(STEPS) << (NSTG - 1 - k);
    assign red[k+1] = (red[k] >= LIM) ? red[k] - LIM : red[k];
  end

  assign idx = red[NSTG][IDX_W-1:0];

  logic unused_hi;
  assign unused_hi = ^red[NSTG][WW-1:IDX_W];
endmodule

// File: rtl/sincos_rom.sv
module sincos_rom #(
  parameter int unsigned STEPS     = sincos_pkg::TABLE_STEPS,
  parameter int unsigned VAL_W     = sincos_pkg::VALUE_BITS,
  parameter int unsigned VAL_FRAC  = sincos_pkg::VALUE_FRAC_BITS,
  localparam int unsigned IDX_W    = $clog2(STEPS)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [VAL_W-1:0] sin_o,
  output logic [VAL_W-1:0] cos_o
);
  // magnitude rounded to nearest; negative values stored inverted
  function automatic logic [VAL_W-1:0] quant(input real v);
    real mag;
    int  m;
    logic [VAL_W-1:0] mv;
    mag = (v < 0.0) ? -v : v;
    m   = $rtoi(mag * real'(1 << VAL_FRAC) + 0.5);
    mv  = VAL_W'(m);
    return (v < 0.0 && m != 0) ? ~mv : mv;
  endfunction

  logic [VAL_W-1:0] sin_tab [STEPS];
  logic [VAL_W-1:0] cos_tab [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_ent
    localparam real              PH = 2.0 * sincos_pkg::PI_R * i / STEPS;
    localparam logic [VAL_W-1:0] SV = quant($sin(PH));
    localparam logic [VAL_W-1:0] CV = quant($cos(PH));
    assign sin_tab[i] = SV;
    assign cos_tab[i] = CV;
  end

  assign sin_o = sin_tab[idx];
  assign cos_o = cos_tab[idx];
endmodule

// File: rtl/sincos_table_gen.sv
module sincos_table_gen #(
  parameter int unsigned INT_BITS  = sincos_pkg::ANGLE_INT_BITS,
  parameter int unsigned FRAC_BITS = sincos_pkg::ANGLE_FRAC_BITS,
  parameter int unsigned STEPS     = sincos_pkg::TABLE_STEPS,
  parameter int unsigned VAL_W     = sincos_pkg::VALUE_BITS,
  parameter int unsigned VAL_FRAC  = sincos_pkg::VALUE_FRAC_BITS,
  localparam int unsigned ANG_W    = 1 + INT_BITS + FRAC_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ANG_W-1:0] in_angle,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VAL_W-1:0] out_sin,
  output logic [VAL_W-1:0] out_cos
);
  localparam int unsigned IDX_W = $clog2(STEPS);

  logic [IDX_W-1:0] tab_idx;
  logic [VAL_W-1:0] rd_sin, rd_cos;

  sincos_angle_index #(
    .INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .STEPS(STEPS)
  ) i_index (
    .angle(in_angle), .idx(tab_idx)
  );

  sincos_rom #(
    .STEPS(STEPS), .VAL_W(VAL_W), .VAL_FRAC(VAL_FRAC)
  ) i_rom (
    .idx(tab_idx), .sin_o(rd_sin), .cos_o(rd_cos)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sin   <= '0;
      out_cos   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sin <= rd_sin;
        out_cos <= rd_cos;
      end
    end
  end
endmodule

// File: rtl/sincos_table_gen_chk.sv
module sincos_table_gen_chk #(
  parameter int unsigned STEPS    = sincos_pkg::TABLE_STEPS,
  parameter int unsigned VAL_W    = sincos_pkg::VALUE_BITS,
  parameter int unsigned VAL_FRAC = sincos_pkg::VALUE_FRAC_BITS,
  localparam int unsigned IDX_W   = $clog2(STEPS)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VAL_W-1:0] out_sin,
  input logic [VAL_W-1:0] out_cos,
  input logic [IDX_W-1:0] tab_idx
);
  localparam int LO = -(1 << VAL_FRAC) - 1;
  localparam int HI = (1 << VAL_FRAC);

  // R3
  idx_in_table_chk: assert property (@(posedge clk) disable iff (rst)
    int'(tab_idx) < STEPS);

  // R4
  sin_span_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_sin) >= LO && $signed(out_sin) <= HI));

  // R4
  cos_span_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_cos) >= LO && $signed(out_cos) <= HI));

  // R5
  accept_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sin) && $stable(out_cos)));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sin == '0 && out_cos == '0));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind sincos_table_gen sincos_table_gen_chk #(
  .STEPS(STEPS), .VAL_W(VAL_W), .VAL_FRAC(VAL_FRAC)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_sin(out_sin), .out_cos(out_cos), .tab_idx(tab_idx)
);

// File: tb/test_sincos_table_gen.sv
`timescale 1ns/1ps
module test_sincos_table_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_angle = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [11:0] out_sin, out_cos;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sincos_table_gen i_sincos_table_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .out_valid(out_valid), .out_ready(out_ready),
    .out_sin(out_sin), .out_cos(out_cos)
  );

  // ---- reference model from the requirements ----
  function automatic int ref_idx(input int a);       // R2, R3
    int q, h;
    q = a + 8;
    h = (q >= 0) ? q / 16 : -((-q + 15) / 16);
    return ((h % 720) + 720) % 720;
  endfunction

  function automatic int ref_code(input real v);     // R4
    real mag;
    int  m;
    mag = (v < 0.0) ? -v : v;
    m   = $rtoi(mag * 1024.0 + 0.5);
    return (v < 0.0 && m != 0) ? ((~m) & 12'hFFF) : m;
  endfunction

  function automatic int ref_sin(input int a);
    return ref_code($sin(2.0 * 3.14159265358979323846 * ref_idx(a) / 720));
  endfunction

  function automatic int ref_cos(input int a);
    return ref_code($cos(2.0 * 3.14159265358979323846 * ref_idx(a) / 720));
  endfunction

  int m_valid = 0, m_sin = 0, m_cos = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_sin = 0; m_cos = 0;
    end else if (!m_valid || out_ready) begin
      if (in_valid) begin
        m_valid = 1;
        m_sin = ref_sin($signed(in_angle));
        m_cos = ref_cos($signed(in_angle));
      end else begin
        m_valid = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R5/R8 out_valid", int'(out_valid), m_valid);
      check("R6 in_ready", int'(in_ready), (!m_valid || out_ready) ? 1 : 0);
      if (m_valid || rst) begin
        check("R4 out_sin", int'(out_sin), m_sin);
        check("R4 out_cos", int'(out_cos), m_cos);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // one angle through an idle block, explicit expected values
  task automatic one(input int a, input int es, input int ec, input string req);
    tick();
    in_valid = 1'b1; in_angle = 18'(a); out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " sin"}, int'(out_sin), es);
    check({req, " cos"}, int'(out_cos), ec);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    // R7 reset state
    check("R7 out_valid", int'(out_valid), 0);
    check("R7 out_sin", int'(out_sin), 0);
    check("R7 out_cos", int'(out_cos), 0);
    rst = 1'b0;
    tick();

    // R4 / R1 anchor values (angle LSB = 1/32 degree)
    one(240 * 32, ref_sin(240 * 32), 12'hDFF, "R4 240deg");
    one(0,        12'h000, 12'h400, "R4 0deg");
    one(90 * 32,  12'h400, 12'h000, "R4 90deg");
    one(180 * 32, 12'h000, 12'hBFF, "R4 180deg");
    one(270 * 32, 12'hBFF, 12'h000, "R4 270deg");
    one(-90 * 32, 12'hBFF, 12'h000, "R3 -90deg");
    one(360 * 32, 12'h000, 12'h400, "R3 360deg");
    one(-131072,  ref_code($sin(3.14159265358979323846 * 448 / 360)),
                  ref_code($cos(3.14159265358979323846 * 448 / 360)), "R3 min");
    one(131071,   ref_code($sin(3.14159265358979323846 * 272 / 360)),
                  ref_code($cos(3.14159265358979323846 * 272 / 360)), "R3 max");
    // R2 rounding around step boundaries
    one(8,  ref_code($sin(3.14159265358979323846 / 360)),
            ref_code($cos(3.14159265358979323846 / 360)), "R2 tie up");
    one(7,  12'h000, 12'h400, "R2 below tie");
    one(-8, 12'h000, 12'h400, "R2 neg tie");
    one(-9, ref_code($sin(3.14159265358979323846 * 719 / 360)),
            ref_code($cos(3.14159265358979323846 * 719 / 360)), "R2 neg below");

    // R4 full sweep, streaming back to back
    for (int k = 0; k < 720; k++) begin
      tick();
      in_valid = 1'b1; in_angle = 18'(k * 16); out_ready = 1'b1;
    end
    tick();
    in_valid = 1'b0;
    tick();
    check("R8 drained", int'(out_valid), 0);

    // R6 explicit stall: held result, new angle ignored
    in_valid = 1'b1; in_angle = 18'(30 * 32); out_ready = 1'b0;
    tick();
    in_angle = 18'(45 * 32);
    repeat (3) tick();
    check("R6 held sin", int'(out_sin), 12'h200);
    check("R6 in_ready low", int'(in_ready), 0);
    in_valid = 1'b0; out_ready = 1'b1;
    tick();

    // R5 R6 random traffic with stalls, many wrapped angles
    for (int k = 0; k < 3000; k++) begin
      tick();
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      in_angle  = 18'($urandom);
    end
    tick();
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) tick();
    check("R8 final drain", int'(out_valid), 0);
    finish_run();
  end
endmodule